// File: doc/BRIEF.md
# Clock Output Mode and Power Controller

This block sits between a clock generator's analog sources and its differential output driver. It decides what the output pair carries. A power-down input takes precedence over a stop input, and the stop input takes precedence over a three-bit mode code. Between them they pick one of several outputs: the phase-aligned clock, the PLL clock, the reference clock, a parked level, a ground level, or high impedance. The block also turns a two-bit multiplier code into the PLL multiplication factor. It reports that factor as three times its value, so that the one fractional setting stays an integer.

The configuration pins (mode and multiplier) are meant to be set while the part is powered down. The block copies them into holding registers on every clock edge while power-down is asserted. It freezes them when power-down is released. From then on, any change on those pins has no effect on the output. Such a change sets a violation flag that stays set until reset.

The operating state is registered and shown on a two-bit output. The output steering is combinational from that state, so the source clocks pass straight through to the pins. The output is not required to be glitch-free when the state changes.

Top module: `clkout_mode_ctrl`

## Requirements
- R1: `op_state` encodes NORMAL=00, CLKSTOP=01 and POWERDOWN=10, and takes the state decoded from the inputs one clock edge after they are applied. `pd_n`=0 gives POWERDOWN whatever `stop_n` is; `pd_n`=1 with `stop_n`=0 gives CLKSTOP; both high give NORMAL. While `rst_n` is low at a clock edge, the state becomes POWERDOWN, the held configuration becomes zero and `cfg_viol` clears.
- R2: In POWERDOWN, `out_p`=0, `out_n`=0 and `out_en`=1.
- R3: In CLKSTOP, `out_p`=1, `out_n`=1 and `out_en`=1, whatever the held mode code is.
- R4: In NORMAL, the held mode code `mode_sel`={S2,S1,S0} selects the true output `out_p`: 000 gives `pa_clk`, 001 gives `pll_clk` and 011 gives `ref_clk`, each with `out_en`=1.
- R5: In NORMAL, mode codes 010 and 110 set `out_en`=0 with `out_p`=`out_n`=0.
- R6: Mode codes 100, 101 and 111 set `mode_bad`=1 in every state, and all other codes set it to 0. In NORMAL these codes drive `out_p`=`out_n`=0 with `out_en`=1.
- R7: In NORMAL with codes 000, 001 or 011, `out_n` is always the logical inverse of `out_p`.
- R8: `mult_x3` shows three times the multiplier selected by the held `mult_sel`={MULT1,MULT0}: 11 gives 24 (x8), 10 gives 18 (x6), 00 gives 12 (x4) and 01 gives 8 (x8/3).
- R9: The configuration is captured at every clock edge where `pd_n`=0 and is held while `pd_n`=1. Pin changes while `pd_n`=1 do not change `mult_x3`, `mode_bad` or the output selection.
- R10: `cfg_viol` becomes 1 at the first clock edge where `pd_n`=1 and `mode_sel` or `mult_sel` differs from the held value. After that it stays 1 until reset, including through later power-down periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Power-down request, active low |
| stop_n | input | 1 | Output stop request, active low |
| mode_sel | input | 3 | Output mode code {S2,S1,S0} |
| mult_sel | input | 2 | PLL multiplier code {MULT1,MULT0} |
| pa_clk | input | 1 | Phase-aligned clock source |
| pll_clk | input | 1 | PLL clock source |
| ref_clk | input | 1 | Reference clock source |
| out_p | output | 1 | True output |
| out_n | output | 1 | Complement output |
| out_en | output | 1 | Output drive enable; 0 means high impedance |
| mult_x3 | output | 5 | Three times the selected PLL multiplier |
| op_state | output | 2 | Current operating state |
| mode_bad | output | 1 | Held mode code is a test or reserved code |
| cfg_viol | output | 1 | Sticky flag for a configuration change outside power-down |

## Verification
A wrong state register shows up in `op_state` and in the output levels at the first edge after `pd_n` or `stop_n` moves. A held configuration that failed to freeze shows up in `mult_x3`, `mode_bad` or the selected source as soon as the pins move outside power-down. A bad capture shows up in those outputs at the edge after power-down is entered. An error in the violation logic is seen on `cfg_viol` one edge after the offending pin change, or when it fails to stay set afterwards. For every mode code and multiplier code, the sweep walks through power-down, NORMAL and CLKSTOP, and it drives every combination of the three source clocks while in NORMAL.

// File: rtl/clkout_pkg.sv
// Shared types for the clock output mode and power controller.
// Assumes op_state_e values are visible at the top-level port.
package clkout_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'b00,
        ST_STOP   = 2'b01,
        ST_PDOWN  = 2'b10
    } op_state_e;

    typedef enum logic [2:0] {
        SRC_PA  = 3'd0,
        SRC_PLL = 3'd1,
        SRC_REF = 3'd2,
        SRC_HIZ = 3'd3,
        SRC_LOW = 3'd4
    } src_e;
endpackage

// File: rtl/clkout_state_reg.sv
// Operating state register. Power-down has priority over stop.
// Assumes pd_n and stop_n are already synchronous to clk.
module clkout_state_reg
    import clkout_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_n,
    input  logic      stop_n,
    output op_state_e state_q
);
    // Register the prioritised state decode.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= ST_PDOWN;
        else if (!pd_n)   state_q <= ST_PDOWN;
        else if (!stop_n) state_q <= ST_STOP;
        else              state_q <= ST_NORMAL;
    end

    // R1: a power-down request always wins at the next edge
    p_pdown_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> state_q == ST_PDOWN);

    // R1: stop alone gives CLKSTOP
    p_stop_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !stop_n) |=> state_q == ST_STOP);

    // R1: the unused encoding never appears
    p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'b11);
endmodule

// File: rtl/clkout_cfg_hold.sv
// Configuration holding registers. They follow the pins while power-down
// is active and freeze afterwards. A pin mismatch while frozen sets a
// sticky violation flag. Assumes the pins are synchronous to clk.
module clkout_cfg_hold #(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic [CFG_W-1:0] cfg_in,
    output logic [CFG_W-1:0] cfg_q,
    output logic             viol_q
);
    logic [CFG_W-1:0] diff;

    for (genvar i = 0; i < CFG_W; i++) begin : g_bit
        // Capture one configuration bit while powered down.
        always_ff @(posedge clk) begin
            if (!rst_n)     cfg_q[i] <= 1'b0;
            else if (!pd_n) cfg_q[i] <= cfg_in[i];
        end
        // Flag this bit if the pin differs from the frozen copy.
        assign diff[i] = pd_n & (cfg_in[i] ^ cfg_q[i]);
    end

    // Sticky violation flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     viol_q <= 1'b0;
        else if (|diff) viol_q <= 1'b1;
    end

    // R9: the held copy does not move while power-down is released
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pd_n |=> $stable(cfg_q));

    // R10: once set, the flag stays set
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> viol_q);

    // R10: a pin change with power-down released is caught
    p_catch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && cfg_in != cfg_q) |=> viol_q);
endmodule

// File: rtl/clkout_mode_dec.sv
// Combinational decode of the held mode code into an output source and a
// status bit, and of the multiplier code into three times the factor.
// Assumes mode {S2,S1,S0} and multiplier {MULT1,MULT0} bit order.
module clkout_mode_dec
    import clkout_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int MULT_W = 2,
    parameter int MUL_W  = 5
) (
    input  logic [MODE_W-1:0] mode_q,
    input  logic [MULT_W-1:0] mult_q,
    output src_e              src,
    output logic              bad,
    output logic [MUL_W-1:0]  mult_x3
);
    localparam logic [MUL_W-1:0] X3_BY8  = MUL_W'(24);
    localparam logic [MUL_W-1:0] X3_BY6  = MUL_W'(18);
    localparam logic [MUL_W-1:0] X3_BY4  = MUL_W'(12);
    localparam logic [MUL_W-1:0] X3_BY83 = MUL_W'(8);

    // Map the mode code to a source and flag the test and reserved codes.
    always_comb begin
        src = SRC_LOW;
        bad = 1'b0;
        case (mode_q[2:0])
            3'b000:         src = SRC_PA;
            3'b001:         src = SRC_PLL;
            3'b011:         src = SRC_REF;
            3'b010, 3'b110: src = SRC_HIZ;
            default: begin
                src = SRC_LOW;
                bad = 1'b1;
            end
        endcase
    end

    // Map the multiplier code to three times the multiplication factor.
    always_comb begin
        case (mult_q[1:0])
            2'b11:   mult_x3 = X3_BY8;
            2'b10:   mult_x3 = X3_BY6;
            2'b00:   mult_x3 = X3_BY4;
            default: mult_x3 = X3_BY83;
        endcase
    end
endmodule

// File: rtl/clkout_steer.sv
// Output steering. The operating state takes priority over the source
// selected by the mode code. Assumes the source clocks come straight
// from the analog blocks. Glitches at state changes are allowed.
module clkout_steer
    import clkout_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  op_state_e state_q,
    input  src_e      src,
    input  logic      pa_clk,
    input  logic      pll_clk,
    input  logic      ref_clk,
    output logic      out_p,
    output logic      out_n,
    output logic      out_en
);
    // Choose the output levels from the state, then from the source.
    always_comb begin
        out_p  = 1'b0;
        out_n  = 1'b0;
        out_en = 1'b1;
        case (state_q)
            ST_PDOWN: begin
                out_p = 1'b0;
                out_n = 1'b0;
            end
            ST_STOP: begin
                out_p = 1'b1;
                out_n = 1'b1;
            end
            ST_NORMAL: begin
                case (src)
                    SRC_PA:  begin out_p = pa_clk;  out_n = ~pa_clk;  end
                    SRC_PLL: begin out_p = pll_clk; out_n = ~pll_clk; end
                    SRC_REF: begin out_p = ref_clk; out_n = ~ref_clk; end
                    SRC_HIZ: out_en = 1'b0;
                    default: begin out_p = 1'b0; out_n = 1'b0; end
                endcase
            end
            default: begin
                out_p = 1'b0;
                out_n = 1'b0;
            end
        endcase
    end

    // R2: power-down drives both pins to ground
    p_pdown_ground_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PDOWN |-> (!out_p && !out_n && out_en));

    // R3: stop parks both pins high
    p_stop_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STOP |-> (out_p && out_n && out_en));

    // R7: clock sources keep the pair complementary
    p_complement_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && (src == SRC_PA || src == SRC_PLL || src == SRC_REF))
        |-> (out_n == !out_p));
endmodule

// File: rtl/clkout_mode_ctrl.sv
// Top of the clock output mode and power controller. It joins the state
// register, the configuration holding registers, the mode decoder and the
// output steering. Assumes all control inputs are synchronous to clk.
module clkout_mode_ctrl
    import clkout_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int MULT_W = 2,
    parameter int MUL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              stop_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [MULT_W-1:0] mult_sel,
    input  logic              pa_clk,
    input  logic              pll_clk,
    input  logic              ref_clk,
    output logic              out_p,
    output logic              out_n,
    output logic              out_en,
    output logic [MUL_W-1:0]  mult_x3,
    output logic [1:0]        op_state,
    output logic              mode_bad,
    output logic              cfg_viol
);
    localparam int CFG_W = MODE_W + MULT_W;

    op_state_e        state_q;
    src_e             src;
    logic [CFG_W-1:0] cfg_q;

    clkout_state_reg u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .stop_n  (stop_n),
        .state_q (state_q)
    );

    clkout_cfg_hold #(.CFG_W(CFG_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_n   (pd_n),
        .cfg_in ({mult_sel, mode_sel}),
        .cfg_q  (cfg_q),
        .viol_q (cfg_viol)
    );

    clkout_mode_dec #(.MODE_W(MODE_W), .MULT_W(MULT_W), .MUL_W(MUL_W)) u_dec (
        .mode_q  (cfg_q[MODE_W-1:0]),
        .mult_q  (cfg_q[CFG_W-1:MODE_W]),
        .src     (src),
        .bad     (mode_bad),
        .mult_x3 (mult_x3)
    );

    clkout_steer u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .src     (src),
        .pa_clk  (pa_clk),
        .pll_clk (pll_clk),
        .ref_clk (ref_clk),
        .out_p   (out_p),
        .out_n   (out_n),
        .out_en  (out_en)
    );

    assign op_state = state_q;

    // R6: an invalid code in NORMAL drives both pins low
    p_bad_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bad && op_state == 2'b00) |-> (!out_p && !out_n && out_en));

    // R5: an undriven output only occurs in NORMAL
    p_hiz_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> op_state == 2'b00);
endmodule

// File: tb/test_clkout_mode_ctrl.sv
// Bench for clkout_mode_ctrl: sweeps every mode and multiplier code
// through power-down, NORMAL and CLKSTOP, then exercises the violation flag.
module test_clkout_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, pd_n, stop_n;
    logic [2:0] mode_sel;
    logic [1:0] mult_sel;
    logic       pa_clk, pll_clk, ref_clk;
    logic       out_p, out_n, out_en;
    logic [4:0] mult_x3;
    logic [1:0] op_state;
    logic       mode_bad, cfg_viol;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    clkout_mode_ctrl i_clkout_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .stop_n(stop_n),
        .mode_sel(mode_sel), .mult_sel(mult_sel),
        .pa_clk(pa_clk), .pll_clk(pll_clk), .ref_clk(ref_clk),
        .out_p(out_p), .out_n(out_n), .out_en(out_en),
        .mult_x3(mult_x3), .op_state(op_state),
        .mode_bad(mode_bad), .cfg_viol(cfg_viol)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected {out_p,out_n,out_en} from R2..R7
    function automatic logic [2:0] exp_out(logic [1:0] st, logic [2:0] m,
                                           logic a, logic b, logic c);
        if (st == 2'b10) return 3'b001;
        if (st == 2'b01) return 3'b111;
        case (m)
            3'b000:         return {a, ~a, 1'b1};
            3'b001:         return {b, ~b, 1'b1};
            3'b011:         return {c, ~c, 1'b1};
            3'b010, 3'b110: return 3'b000;
            default:        return 3'b001;
        endcase
    endfunction

    // Expected three-times multiplier from R8
    function automatic int exp_mult(logic [1:0] mu);
        case (mu)
            2'b11:   return 24;
            2'b10:   return 18;
            2'b00:   return 12;
            default: return 8;
        endcase
    endfunction

    function automatic int exp_bad(logic [2:0] m);
        return (m == 3'b100 || m == 3'b101 || m == 3'b111) ? 1 : 0;
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic final_report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            final_report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pd_n = 1'b1; stop_n = 1'b1;
        mode_sel = 3'b011; mult_sel = 2'b11;
        pa_clk = 1'b0; pll_clk = 1'b0; ref_clk = 1'b0;
        repeat (3) step();
        // R1: reset state
        check("R1 reset state", int'(op_state), 2);
        check("R1 reset viol", int'(cfg_viol), 0);
        check("R1 reset mult", int'(mult_x3), 12);
        check("R2 reset outputs", int'({out_p, out_n, out_en}), 1);

        @(negedge clk);
        rst_n = 1'b1; pd_n = 1'b0;

        for (int m = 0; m < 8; m++) begin
            for (int mu = 0; mu < 4; mu++) begin
                @(negedge clk);
                pd_n = 1'b0; stop_n = 1'b1;
                mode_sel = 3'(m); mult_sel = 2'(mu);
                step();
                check("R1 powerdown state", int'(op_state), 2);
                check("R2 powerdown outputs", int'({out_p, out_n, out_en}), 1);
                check("R8 multiplier", int'(mult_x3), exp_mult(2'(mu)));
                check("R6 mode_bad", int'(mode_bad), exp_bad(3'(m)));

                @(negedge clk);
                pd_n = 1'b1;
                step();
                check("R1 normal state", int'(op_state), 0);
                for (int v = 0; v < 8; v++) begin
                    pa_clk = v[0]; pll_clk = v[1]; ref_clk = v[2];
                    #1;
                    check("R4 R5 R6 R7 normal outputs", int'({out_p, out_n, out_en}),
                          int'(exp_out(2'b00, 3'(m), v[0], v[1], v[2])));
                end

                @(negedge clk);
                stop_n = 1'b0;
                step();
                check("R1 stop state", int'(op_state), 1);
                check("R3 stop outputs", int'({out_p, out_n, out_en}), 7);
                check("R10 no violation", int'(cfg_viol), 0);
                @(negedge clk);
                stop_n = 1'b1;
            end
        end

        // R9 and R10: change pins outside power-down
        @(negedge clk);
        pd_n = 1'b0; mode_sel = 3'b000; mult_sel = 2'b11;
        step();
        @(negedge clk);
        pd_n = 1'b1;
        step();
        check("R10 clean after capture", int'(cfg_viol), 0);
        @(negedge clk);
        mode_sel = 3'b011; mult_sel = 2'b00;
        pa_clk = 1'b1; ref_clk = 1'b0;
        step();
        check("R10 violation set", int'(cfg_viol), 1);
        check("R9 multiplier frozen", int'(mult_x3), 24);
        check("R9 source frozen", int'({out_p, out_n, out_en}), 3'b101);
        check("R9 mode_bad frozen", int'(mode_bad), 0);
        @(negedge clk);
        mode_sel = 3'b000; mult_sel = 2'b11;
        step();
        check("R10 sticky after restore", int'(cfg_viol), 1);
        @(negedge clk);
        pd_n = 1'b0;
        step();
        check("R10 sticky in powerdown", int'(cfg_viol), 1);
        @(negedge clk);
        rst_n = 1'b0;
        step();
        check("R1 reset clears viol", int'(cfg_viol), 0);

        done = 1'b1;
        final_report();
        $finish;
    end
endmodule